// File: doc/BRIEF.md
# Page Load Controller

This block is the write front end of a page-programmed non-volatile store. A synchronous host port presents an address, a 16-bit data word and a write strobe, qualified by a select and an output-enable level. Accepted writes are gathered into a 128-word page buffer. The page number taken from the first accepted word is locked, and every later word in the same window must carry that page number. Each accepted word reopens a load window. When the window runs out with no new word, a self-timed program cycle starts. At the end of that cycle the whole page is written to a behavioural storage array in a single clock, and any word that was not loaded is written as all-ones.

The controller is built around one state machine with four states. `S_POR` is the power-on hold after reset. `S_IDLE` waits for a first word. `S_LOAD` is the open load window. `S_PROG` is the program cycle. The transitions are as follows. S_POR→S_IDLE when the power-on count expires. S_IDLE→S_LOAD on an accepted write. S_LOAD→S_LOAD on an accepted write to the locked page, which restarts the window. S_LOAD→S_PROG when the window count expires in a cycle with no accepted write. S_PROG→S_IDLE on commit, when the program count expires. A single down-counter is reloaded on each transition and serves all three timed states.

Top module: `page_load_ctrl`

## Requirements
- R1: While reset is asserted, `busy` is 1, `page_err` is 0, `last_addr` and `last_data` are 0, and every array word reads FFFFh.
- R2: After reset is released, writes are ignored and `busy` stays 1 for exactly POR_CYC clock edges. `busy` reads 0 after that edge.
- R3: Words may be loaded in any order. After commit, each loaded word reads back from the array at its address. If a word is loaded twice, the later data is kept.
- R4: After commit, every word of the programmed page that was not loaded in the window reads FFFFh.
- R5: An accepted write restarts the window, even on the edge where the count has just reached zero. `busy` rises on the WIN_CYC-th edge after the last accepted write.
- R6: `busy` stays 1 for PROG_CYC edges. The array still returns the old data until the edge where `busy` falls, and it returns the new page from that edge on.
- R7: During an open window, a write whose page field differs from the locked page is dropped, does not restart the window, and sets `page_err`. `page_err` stays set until reset.
- R8: A write strobe with `host_oe`=1 or `host_sel`=0 has no effect. It does not change `last_addr` or `last_data`, it does not open a window, and it writes nothing to the array.
- R9: Writes presented while `busy` is 1 are ignored.
- R10: The record of loaded words is cleared at commit. A later window that loads one word writes all-ones to every other word of that page.
- R11: `last_addr` and `last_data` hold the address and data of the most recent accepted write.
- R12: Address bits [6:0] select the word in the page. Bits [ADDR_W-1:7] select the page, so the array location is {page, word}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Write strobe, one cycle per word |
| host_sel | input | 1 | Select, active high; a write needs it at 1 |
| host_oe | input | 1 | Output enable, active high; blocks writes |
| host_addr | input | ADDR_W | Write address {page, word} |
| host_wdata | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data, combinational |
| busy | output | 1 | 1 in the power-on hold and in the program cycle |
| page_err | output | 1 | Sticky flag for a dropped write to a different page |
| last_addr | output | ADDR_W | Address of the last accepted write |
| last_data | output | DATA_W | Data of the last accepted write |

## Verification
An accepted write lands in `last_addr`/`last_data` one edge later. `busy` rises exactly WIN_CYC edges after the last accepted write. Commit and the fall of `busy` follow PROG_CYC edges after that. The bench drives on falling edges and samples at the falling edge that follows the edge where each result is due. It also samples at the edge just before, to pin both sides of each boundary. Array reads are combinational, so they are sampled one nanosecond after `rd_addr` is set, well away from any rising edge.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        S_POR  = 2'd0,
        S_IDLE = 2'd1,
        S_LOAD = 2'd2,
        S_PROG = 2'd3
    } plc_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/plc_timer.sv
module plc_timer #(
    parameter int CW      = 4,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CW'(RST_VAL);
        end else if (ld) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/plc_page_buf.sv
module plc_page_buf #(
    parameter int DATA_W    = 16,
    parameter int WORD_BITS = 7,
    localparam int PW       = 1 << WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [WORD_BITS-1:0] widx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 clr,
    output logic [PW*DATA_W-1:0] page_img
);

    logic [DATA_W-1:0] words [PW];
    logic [PW-1:0]     loaded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded <= '0;
        end else if (clr) begin
            loaded <= '0;
        end else if (we) begin
            loaded[widx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            words[widx] <= wdata;
        end
    end

    for (genvar i = 0; i < PW; i++) begin : g_fill
        assign page_img[i*DATA_W +: DATA_W] = loaded[i] ? words[i] : {DATA_W{1'b1}};
    end

endmodule

// File: rtl/plc_array.sv
module plc_array #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 9,
    parameter int WORD_BITS = 7,
    localparam int PW       = 1 << WORD_BITS,
    localparam int PB       = ADDR_W - WORD_BITS,
    localparam int DEPTH    = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [PB-1:0]        page,
    input  logic [PW*DATA_W-1:0] page_img,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                cells[k] <= {DATA_W{1'b1}};
            end
        end else if (commit) begin
            for (int i = 0; i < PW; i++) begin
                cells[{page, WORD_BITS'(i)}] <= page_img[i*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 9,
    parameter int WORD_BITS = 7,
    parameter int WIN_CYC   = 8,
    parameter int PROG_CYC  = 12,
    parameter int POR_CYC   = 6,
    localparam int PW       = 1 << WORD_BITS,
    localparam int PB       = ADDR_W - WORD_BITS,
    localparam int CW       = $clog2(max3(WIN_CYC, PROG_CYC, POR_CYC) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic              host_oe,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              page_err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);

    plc_state_e     state, state_nxt;
    logic [PB-1:0]  lock_page;
    logic [PB-1:0]  in_page;
    logic           wr_ok, match, acc, mis, win_end, commit;
    logic           tmr_zero, tmr_ld;
    logic [CW-1:0]  tmr_val;
    logic [PW*DATA_W-1:0] page_img;

    assign in_page = host_addr[ADDR_W-1:WORD_BITS];
    assign wr_ok   = host_wr && host_sel && !host_oe;
    assign match   = (in_page == lock_page);
    assign acc     = wr_ok && ((state == S_IDLE) || ((state == S_LOAD) && match));
    assign mis     = wr_ok && (state == S_LOAD) && !match;
    assign win_end = (state == S_LOAD) && !acc && tmr_zero;
    assign commit  = (state == S_PROG) && tmr_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_POR;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and timer reload
    always_comb begin
        state_nxt = state;
        tmr_ld    = 1'b0;
        tmr_val   = '0;
        unique case (state)
            S_POR: begin
                if (tmr_zero) state_nxt = S_IDLE;
            end
            S_IDLE: begin
                if (acc) begin
                    state_nxt = S_LOAD;
                    tmr_ld    = 1'b1;
                    tmr_val   = CW'(WIN_CYC - 1);
                end
            end
            S_LOAD: begin
                if (acc) begin
                    tmr_ld  = 1'b1;
                    tmr_val = CW'(WIN_CYC - 1);
                end else if (win_end) begin
                    state_nxt = S_PROG;
                    tmr_ld    = 1'b1;
                    tmr_val   = CW'(PROG_CYC - 1);
                end
            end
            S_PROG: begin
                if (commit) state_nxt = S_IDLE;
            end
            default: state_nxt = S_POR;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_page <= '0;
            page_err  <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (acc) begin
                last_addr <= host_addr;
                last_data <= host_wdata;
            end
            if (acc && (state == S_IDLE)) begin
                lock_page <= in_page;
            end
            if (mis) begin
                page_err <= 1'b1;
            end
        end
    end

    assign busy = (state == S_POR) || (state == S_PROG);

    plc_timer #(
        .CW      (CW),
        .RST_VAL (POR_CYC - 1)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (tmr_ld),
        .ld_val (tmr_val),
        .zero   (tmr_zero)
    );

    plc_page_buf #(
        .DATA_W    (DATA_W),
        .WORD_BITS (WORD_BITS)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (acc),
        .widx     (host_addr[WORD_BITS-1:0]),
        .wdata    (host_wdata),
        .clr      (commit),
        .page_img (page_img)
    );

    plc_array #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .WORD_BITS (WORD_BITS)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .page     (lock_page),
        .page_img (page_img),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/plc_checks.sv
module plc_checks
    import plc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 9,
    parameter int WORD_BITS = 7,
    localparam int PB       = ADDR_W - WORD_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_sel,
    input logic              host_oe,
    input logic              busy,
    input logic              page_err,
    input logic              acc,
    input plc_state_e        state,
    input logic [PB-1:0]     lock_page,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data
);

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    assert_gated_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_oe || !host_sel)) |=> ($stable(last_addr) && $stable(last_data)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);

    assert_load_reopens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !busy);

    assert_same_page_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD) |-> (last_addr[ADDR_W-1:WORD_BITS] == lock_page));

endmodule

bind page_load_ctrl plc_checks #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .WORD_BITS (WORD_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_sel  (host_sel),
    .host_oe   (host_oe),
    .busy      (busy),
    .page_err  (page_err),
    .acc       (acc),
    .state     (state),
    .lock_page (lock_page),
    .last_addr (last_addr),
    .last_data (last_data)
);

// File: tb/page_load_ctrl_bench.sv
module page_load_ctrl_bench;

    localparam int AW  = 9;
    localparam int DW  = 16;
    localparam int WB  = 7;
    localparam int WIN = 8;
    localparam int PRG = 12;
    localparam int POR = 6;
    localparam int NV  = 8;

    // entry format: {word index[15:0], data[15:0]}, all to page 1
    localparam logic [31:0] VEC [NV] = '{
        32'h0005_1A05, 32'h0000_2B00, 32'h007F_3C7F, 32'h0040_4D40,
        32'h0003_5E03, 32'h0064_6F64, 32'h002A_702A, 32'h0005_815F
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, host_wr, host_sel, host_oe;
    logic [AW-1:0] host_addr, rd_addr, last_addr;
    logic [DW-1:0] host_wdata, rd_data, last_data;
    logic          busy, page_err;

    int n_chk  = 0;
    int n_fail = 0;

    page_load_ctrl #(
        .DATA_W(DW), .ADDR_W(AW), .WORD_BITS(WB),
        .WIN_CYC(WIN), .PROG_CYC(PRG), .POR_CYC(POR)
    ) u_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_oe(host_oe), .host_addr(host_addr), .host_wdata(host_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .page_err(page_err),
        .last_addr(last_addr), .last_data(last_data)
    );

    function automatic logic [AW-1:0] ad(input int page, input int idx);
        return {(AW-WB)'(page), WB'(idx)};
    endfunction

    function automatic logic [DW-1:0] vec_exp(input int idx);
        logic [DW-1:0] v;
        v = 16'hFFFF;
        for (int j = 0; j < NV; j++) begin
            if (int'(VEC[j][31:16]) == idx) v = VEC[j][15:0];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    // called at a falling edge; the write is taken at the next rising edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic sel = 1'b1, input logic oe = 1'b0);
        host_wr = 1'b1; host_sel = sel; host_oe = oe;
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0; host_oe = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_oe = 1'b0;
        host_addr = '0; host_wdata = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd1);
        chk("R1 page_err", 32'(page_err), 32'd0);
        chk("R1 last_addr", 32'(last_addr), 32'd0);
        chk("R1 last_data", 32'(last_data), 32'd0);
        rd_chk("R1 array", ad(1, 5), 16'hFFFF);
        rst_n = 1'b1;

        // R2 power-on hold: write ignored, busy for POR edges
        wr(ad(1, 3), 16'h1234);
        repeat (POR - 2) @(negedge clk);
        chk("R2 busy held", 32'(busy), 32'd1);
        chk("R2 write ignored", 32'(last_addr), 32'd0);
        @(negedge clk);
        chk("R2 busy released", 32'(busy), 32'd0);

        // R3 vector table: out-of-order loads to page 1
        for (int i = 0; i < NV; i++) begin
            wr(ad(1, int'(VEC[i][31:16])), VEC[i][15:0]);
        end
        chk("R11 last_addr", 32'(last_addr), 32'(ad(1, int'(VEC[NV-1][31:16]))));
        chk("R11 last_data", 32'(last_data), 32'(VEC[NV-1][15:0]));
        repeat (WIN - 1) @(negedge clk);
        chk("R5 window open", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R5 program start", 32'(busy), 32'd1);
        // R9 write while busy
        wr(ad(1, 9), 16'hBEEF);
        chk("R9 last_addr kept", 32'(last_addr), 32'(ad(1, int'(VEC[NV-1][31:16]))));
        repeat (PRG - 2) @(negedge clk);
        chk("R6 busy held", 32'(busy), 32'd1);
        rd_chk("R6 old data", ad(1, 0), 16'hFFFF);
        @(negedge clk);
        chk("R6 busy released", 32'(busy), 32'd0);
        for (int i = 0; i < NV; i++) begin
            rd_chk("R3 committed word", ad(1, int'(VEC[i][31:16])), vec_exp(int'(VEC[i][31:16])));
        end
        rd_chk("R4 unloaded 2", ad(1, 2), 16'hFFFF);
        rd_chk("R4 unloaded 126", ad(1, 126), 16'hFFFF);
        rd_chk("R9 busy write dropped", ad(1, 9), 16'hFFFF);

        // R10 valid bits cleared: one word reprograms page 1
        wr(ad(1, 7), 16'h7777);
        repeat (WIN + PRG) @(negedge clk);
        chk("R10 idle", 32'(busy), 32'd0);
        rd_chk("R10 new word", ad(1, 7), 16'h7777);
        rd_chk("R10 old word erased", ad(1, 5), 16'hFFFF);

        // R7 page mismatch
        wr(ad(2, 4), 16'hAAAA);
        wr(ad(3, 4), 16'hBBBB);
        chk("R7 page_err set", 32'(page_err), 32'd1);
        chk("R7 last_addr kept", 32'(last_addr), 32'(ad(2, 4)));
        repeat (WIN - 2) @(negedge clk);
        chk("R7 window not restarted", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R7 program start", 32'(busy), 32'd1);
        repeat (PRG) @(negedge clk);
        rd_chk("R12 page 2 word 4", ad(2, 4), 16'hAAAA);
        rd_chk("R12 page 0 word 4", ad(0, 4), 16'hFFFF);
        rd_chk("R7 dropped word", ad(3, 4), 16'hFFFF);
        chk("R7 sticky", 32'(page_err), 32'd1);

        // R5 reload on the edge where the count reached zero
        wr(ad(0, 1), 16'h1111);
        repeat (WIN - 1) @(negedge clk);
        wr(ad(0, 2), 16'h2222);
        chk("R5 restarted", 32'(busy), 32'd0);
        repeat (WIN - 1) @(negedge clk);
        chk("R5 window after restart", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R5 program after restart", 32'(busy), 32'd1);
        repeat (PRG) @(negedge clk);
        rd_chk("R5 first word", ad(0, 1), 16'h1111);
        rd_chk("R5 second word", ad(0, 2), 16'h2222);

        // R8 gated strobes
        wr(ad(0, 9), 16'h9999, 1'b1, 1'b1);
        wr(ad(0, 9), 16'h9998, 1'b0, 1'b0);
        chk("R8 last_addr kept", 32'(last_addr), 32'(ad(0, 2)));
        chk("R8 last_data kept", 32'(last_data), 32'h2222);
        repeat (WIN + PRG + 2) @(negedge clk);
        chk("R8 no program", 32'(busy), 32'd0);
        rd_chk("R8 array untouched", ad(0, 9), 16'hFFFF);

        summary();
        $finish;
    end

endmodule